// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Transmit and Receive Queues

This block is an asynchronous serial transmitter and receiver for 8N1 frames. Each direction has a 16-entry byte queue. Software reaches the block through a four-address byte register port: a control word, a divisor, a data window and a status word. A write to the data window queues a byte for sending. A read of the data window pops the oldest received byte.

Both directions run from one 16x oversampling tick. A two-bit clock-select field picks where the tick comes from. It is either an internal counter that divides the system clock by a programmable divisor plus one, or the rising edges of an external pin that runs at sixteen times the bit rate. In internal mode the block can also drive a 16x clock on a pin of its own.

Separate enable bits start and stop the transmitter and the receiver. Turning the transmitter off resets only its shifter and floats the serial output. Queue contents and status flags survive until software writes an explicit flush bit or clears a flag.

Top module: `uart_fifo_core`

## Requirements
- R1: A transmitted frame is one low start bit, eight data bits with the LSB first, and one high stop bit. Each bit lasts 16 ticks. While the transmitter is enabled, the line sits high between frames.
- R2: With clock select 00 or 01, one tick occurs every (divisor+1) system clocks. One bit therefore lasts 16*(divisor+1) system clocks, for every divisor from 0 to 255.
- R3: Clock select 1x takes the tick from rising edges of `xclk_i`, so a bit lasts 16 external periods. Clock select 01 sets `xclk_oe_o` and drives `xclk_o` with one rising edge per tick. Clock select 00 or 1x leaves `xclk_oe_o` low.
- R4: Clearing the transmit enable (CTRL bit 0) drops `txd_oe_o` on the next clock and abandons any frame in progress. After re-enabling, the next queued byte goes out as a complete, fresh frame.
- R5: Clearing either enable bit leaves the transmit queue, the receive queue and the status flags unchanged.
- R6: The transmit-end flag (STAT bit 0) is 1 after reset. A write to DATA clears it. It is set again once the stop bit of a byte has fully left the shifter and the transmit queue is empty.
- R7: Writing CTRL with bit 4 set empties the transmit queue. Writing CTRL with bit 5 set empties the receive queue.
- R8: The receiver waits for a high-to-low transition and confirms the start bit 8 ticks later. It samples each data bit and the stop bit 16 ticks after the previous sample, then pushes the byte. A low pulse shorter than 8 ticks is rejected.
- R9: A stop bit sampled low sets the framing-error flag (STAT bit 6). The byte is still queued. Writing 1 to STAT bit 6 clears the flag.
- R10: A write to DATA while the transmit queue holds 16 bytes is dropped. A byte received while the receive queue holds 16 bytes is dropped and sets the overrun flag (STAT bit 5). Writing 1 to STAT bit 5 clears the overrun flag.
- R11: Register map:
  - address 0 is CTRL, with bit 0 transmit enable, bit 1 receive enable, bits 3:2 clock select, and bits 4 and 5 the flush strobes;
  - address 1 is DIV;
  - address 2 is DATA, which reads 0 when the receive queue is empty;
  - address 3 is STAT, with bit 0 transmit end, bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full, bit 5 overrun and bit 6 framing error.

  After reset, CTRL is 0x00, STAT is 0x0D and `txd_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the receive queue at DATA) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| txd_oe_o | output | 1 | Output enable for the transmit line; low means floating |
| xclk_i | input | 1 | External 16x clock input |
| xclk_o | output | 1 | 16x clock output in internal mode |
| xclk_oe_o | output | 1 | Output enable for the clock pin |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, 16-entry queues and 16x oversampling. With these defaults, a full queue of sixteen frames fits easily in the cycle budget, so the full-queue and overrun edges can be reached.

The bench sets divisors from 0 to 7, giving bit periods of 16 to 128 system clocks. It also drives an external clock with a six-cycle period. Together these exercise the divider terminal count at its minimum, several rates, and both tick sources.

Most frames travel through a loopback path, so the receiver is tested against the transmitter. Framing errors and false starts come from a separately driven line.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned DATA_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // CTRL bit positions
  localparam int unsigned C_TX_EN   = 0;
  localparam int unsigned C_RX_EN   = 1;
  localparam int unsigned C_SEL_LO  = 2;
  localparam int unsigned C_TX_FLSH = 4;
  localparam int unsigned C_RX_FLSH = 5;

  // STAT bit positions (W1C for overrun and framing error)
  localparam int unsigned S_OVR  = 5;
  localparam int unsigned S_FERR = 6;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sel_ext_i,
  input  logic             ext_clk_i,
  output logic             tick_o,
  output logic             clk_out_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             int_tick;
  logic [2:0]       ext_sync_q;
  logic             ext_tick;

  // >= so that lowering the divisor never strands the counter above it
  assign int_tick = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (int_tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_sync_q <= '0;
    end else begin
      ext_sync_q <= {ext_sync_q[1:0], ext_clk_i};
    end
  end

  assign ext_tick  = ext_sync_q[1] & ~ext_sync_q[2];
  assign tick_o    = sel_ext_i ? ext_tick : int_tick;
  assign clk_out_o = (cnt_q > (div_i >> 1));
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wptr_q, rptr_q;
  logic             do_push, do_pop;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wptr_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R7
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              pop_o,
  output logic              txd_o,
  output logic              done_o
);
  localparam int unsigned SW    = $clog2(OSR);
  localparam int unsigned FRAME = DATA_W + 2;
  localparam int unsigned NW    = $clog2(FRAME + 1);

  logic [FRAME-1:0] shreg_q;
  logic [SW-1:0]    sub_q;
  logic [NW-1:0]    nbits_q;
  logic             busy_q;

  assign pop_o = en_i && tick_i && !busy_q && !fifo_empty_i;
  assign txd_o = shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      sub_q   <= '0;
      nbits_q <= '0;
      busy_q  <= 1'b0;
      done_o  <= 1'b0;
    end else if (!en_i) begin
      shreg_q <= '1;
      sub_q   <= '0;
      nbits_q <= '0;
      busy_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        if (!busy_q && !fifo_empty_i) begin
          shreg_q <= {1'b1, fifo_data_i, 1'b0};
          sub_q   <= '0;
          nbits_q <= NW'(FRAME);
          busy_q  <= 1'b1;
        end else if (busy_q) begin
          if (sub_q == SW'(OSR - 1)) begin
            sub_q   <= '0;
            shreg_q <= {1'b1, shreg_q[FRAME-1:1]};
            nbits_q <= nbits_q - 1'b1;
            if (nbits_q == NW'(1)) begin
              busy_q <= 1'b0;
              done_o <= 1'b1;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
      end
    end
  end

  AST_TX_DIS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (txd_o && !done_o)); // R4
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o
);
  localparam int unsigned SW   = $clog2(OSR);
  localparam int unsigned HALF = OSR / 2;
  localparam int unsigned BW   = $clog2(DATA_W);

  rx_state_e     state_q;
  logic [SW-1:0] sub_q;
  logic [BW-1:0] nbit_q;
  logic          prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      nbit_q  <= '0;
      prev_q  <= 1'b1;
      data_o  <= '0;
      push_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else if (!en_i) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      prev_q  <= 1'b1;
      push_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      push_o <= 1'b0;
      ferr_o <= 1'b0;
      if (tick_i) begin
        prev_q <= rxd_i;
        unique case (state_q)
          RX_IDLE: begin
            if (prev_q && !rxd_i) begin
              state_q <= RX_START;
              sub_q   <= '0;
            end
          end
          RX_START: begin
            if (sub_q == SW'(HALF - 1)) begin
              sub_q  <= '0;
              nbit_q <= '0;
              state_q <= rxd_i ? RX_IDLE : RX_DATA;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (sub_q == SW'(OSR - 1)) begin
              sub_q  <= '0;
              data_o <= {rxd_i, data_o[DATA_W-1:1]};
              nbit_q <= nbit_q + 1'b1;
              if (nbit_q == BW'(DATA_W - 1)) state_q <= RX_STOP;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (sub_q == SW'(OSR - 1)) begin
              sub_q   <= '0;
              state_q <= RX_IDLE;
              push_o  <= 1'b1;
              ferr_o  <= !rxd_i;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_DIS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == RX_IDLE && !push_o)); // R8
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core
  import uart_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned OSR        = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        rxd_i,
  output logic        txd_o,
  output logic        txd_oe_o,
  input  logic        xclk_i,
  output logic        xclk_o,
  output logic        xclk_oe_o
);
  logic             tx_en_q, rx_en_q;
  logic [1:0]       clk_sel_q;
  logic [DIV_W-1:0] div_q;
  logic             tx_end_q, ovr_q, ferr_q;
  logic [1:0]       rxd_sync_q;

  logic wr_ctrl, wr_div, wr_data, wr_stat, rd_data;
  logic tx_flush, rx_flush;
  logic tick, clk_out;

  logic              tx_empty, tx_full, tx_pop, tx_line, tx_done;
  logic [DATA_W-1:0] tx_head;
  logic              rx_empty, rx_full, rx_push, rx_ferr;
  logic [DATA_W-1:0] rx_byte, rx_head;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_div   = reg_we_i && (reg_addr_i == ADDR_DIV);
  assign wr_data  = reg_we_i && (reg_addr_i == ADDR_DATA);
  assign wr_stat  = reg_we_i && (reg_addr_i == ADDR_STAT);
  assign rd_data  = reg_re_i && (reg_addr_i == ADDR_DATA);
  assign tx_flush = wr_ctrl && reg_wdata_i[C_TX_FLSH];
  assign rx_flush = wr_ctrl && reg_wdata_i[C_RX_FLSH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      clk_sel_q <= 2'b00;
      div_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_en_q   <= reg_wdata_i[C_TX_EN];
        rx_en_q   <= reg_wdata_i[C_RX_EN];
        clk_sel_q <= reg_wdata_i[C_SEL_LO +: 2];
      end
      if (wr_div) div_q <= reg_wdata_i[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_sync_q <= 2'b11;
    else         rxd_sync_q <= {rxd_sync_q[0], rxd_i};
  end

  // Status flags: set wins over W1C clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_end_q <= 1'b1;
      ovr_q    <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      if (wr_data)                    tx_end_q <= 1'b0;
      else if (tx_done && tx_empty)   tx_end_q <= 1'b1;
      if (rx_push && rx_full)         ovr_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[S_OVR])  ovr_q <= 1'b0;
      if (rx_ferr)                    ferr_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[S_FERR]) ferr_q <= 1'b0;
    end
  end

  uart_baud #(.DIV_W(DIV_W)) i_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div_q),
    .sel_ext_i (clk_sel_q[1]),
    .ext_clk_i (xclk_i),
    .tick_o    (tick),
    .clk_out_o (clk_out)
  );

  uart_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush),
    .push_i  (wr_data),
    .data_i  (reg_wdata_i),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  uart_tx #(.OSR(OSR), .DATA_W(DATA_W)) i_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (tx_en_q),
    .tick_i       (tick),
    .fifo_empty_i (tx_empty),
    .fifo_data_i  (tx_head),
    .pop_o        (tx_pop),
    .txd_o        (tx_line),
    .done_o       (tx_done)
  );

  uart_rx #(.OSR(OSR), .DATA_W(DATA_W)) i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_q),
    .tick_i (tick),
    .rxd_i  (rxd_sync_q[1]),
    .push_o (rx_push),
    .data_o (rx_byte),
    .ferr_o (rx_ferr)
  );

  uart_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (rx_push),
    .data_i  (rx_byte),
    .pop_i   (rd_data),
    .data_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  assign txd_o     = tx_en_q ? tx_line : 1'b1;
  assign txd_oe_o  = tx_en_q;
  assign xclk_oe_o = (clk_sel_q == 2'b01);
  assign xclk_o    = clk_out;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {4'b0, clk_sel_q, rx_en_q, tx_en_q};
      ADDR_DIV:  reg_rdata_o = 8'(div_q);
      ADDR_DATA: reg_rdata_o = rx_empty ? 8'h00 : rx_head;
      default:   reg_rdata_o = {1'b0, ferr_q, ovr_q, rx_full, rx_empty,
                                tx_empty, tx_full, tx_end_q};
    endcase
  end

  AST_TXEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> !tx_end_q); // R6
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full) |=> ovr_q); // R10
  AST_FLOAT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !reg_wdata_i[C_TX_EN]) |=> !txd_oe_o); // R4
endmodule

// File: tb/test_uart_fifo_core.sv
module test_uart_fifo_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       rxd, txd, txd_oe, xclk = 1'b0, xclk_o, xclk_oe;
  logic       lb = 1'b1, rx_drv = 1'b1, ext_run = 1'b0;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  initial forever begin #30; xclk = ext_run ? ~xclk : 1'b0; end

  assign rxd = lb ? (txd_oe ? txd : 1'b1) : rx_drv;

  uart_fifo_core i_uart_fifo_core (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rxd_i(rxd), .txd_o(txd),
    .txd_oe_o(txd_oe), .xclk_i(xclk), .xclk_o(xclk_o), .xclk_oe_o(xclk_oe)
  );

  // {divisor, byte}
  localparam logic [15:0] VEC [6] = '{16'h0355, 16'h03A3, 16'h0001,
                                      16'h0180, 16'h07FF, 16'h0200};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); addr = 2'd2; #1 d = rdata; re = 1'b1;
    @(negedge clk); re = 1'b0;
  endtask

  // Decode one frame on txd; returns at mid stop bit
  task automatic capture(input int bitlen, output logic [7:0] b, output logic st, output logic sp);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (bitlen / 2) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (bitlen) @(negedge clk);
      b[i] = txd;
    end
    repeat (bitlen) @(negedge clk);
    sp = txd;
  endtask

  task automatic send(input logic [7:0] b, input logic stopv, input int bitlen);
    @(negedge clk); rx_drv = 1'b0;
    repeat (bitlen) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv = b[i];
      repeat (bitlen) @(negedge clk);
    end
    rx_drv = stopv;
    repeat (bitlen) @(negedge clk);
    rx_drv = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, b;
    logic st, sp;
    int bl, edges;
    logic prev;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(2'd0, d); chk(d == 8'h00, "R11 ctrl", d, 8'h00);
    rd(2'd3, d); chk(d == 8'h0D, "R11 stat", d, 8'h0D);
    chk(txd_oe == 1'b0, "R11 txd_oe", txd_oe, 0);

    wr(2'd1, 8'h03);
    wr(2'd0, 8'h03);
    repeat (5) @(negedge clk);
    chk(txd == 1'b1 && txd_oe == 1'b1, "R1 idle high", {txd_oe, txd}, 3);
    chk(xclk_oe == 1'b0, "R3 sel00 no clk out", xclk_oe, 0);

    // Vector table: rate and frame via loopback
    foreach (VEC[k]) begin
      bl = 16 * (int'(VEC[k][15:8]) + 1);
      wr(2'd1, VEC[k][15:8]);
      wr(2'd2, VEC[k][7:0]);
      rd(2'd3, d); chk(d[0] == 1'b0, "R6 tx_end cleared", d[0], 0);
      capture(bl, b, st, sp);
      chk(st == 1'b0 && sp == 1'b1, "R1 start/stop", {st, sp}, 1);
      chk(b == VEC[k][7:0], "R2 R1 tx byte", b, VEC[k][7:0]);
      repeat (bl) @(negedge clk);
      rd(2'd3, d); chk(d[0] == 1'b1, "R6 tx_end set", d[0], 1);
      pop(d); chk(d == VEC[k][7:0], "R8 rx loopback", d, VEC[k][7:0]);
    end

    // R3 clock out in internal mode
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h07);
    repeat (4) @(negedge clk);
    chk(xclk_oe == 1'b1, "R3 clk oe", xclk_oe, 1);
    edges = 0; prev = xclk_o;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (xclk_o && !prev) edges++;
      prev = xclk_o;
    end
    chk(edges == 16, "R3 clk out edges", edges, 16);

    // R3 external clock, period 6 cycles
    ext_run = 1'b1;
    wr(2'd0, 8'h0B);
    repeat (4) @(negedge clk);
    chk(xclk_oe == 1'b0, "R3 ext no clk out", xclk_oe, 0);
    wr(2'd2, 8'h3C);
    capture(96, b, st, sp);
    chk(b == 8'h3C, "R3 ext tx byte", b, 8'h3C);
    repeat (200) @(negedge clk);
    pop(d); chk(d == 8'h3C, "R3 ext rx byte", d, 8'h3C);
    wr(2'd0, 8'h03);
    ext_run = 1'b0;

    // R4/R5/R7 disable mid-frame
    wr(2'd2, 8'h11);
    wr(2'd2, 8'h22);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (192) @(negedge clk);
    wr(2'd0, 8'h02);
    chk(txd_oe == 1'b0, "R4 txd floats", txd_oe, 0);
    repeat (800) @(negedge clk);
    rd(2'd3, d); chk(d[2] == 1'b0 && d[0] == 1'b0, "R5 tx queue kept", d, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd3, d); chk(d[2] == 1'b0 && d[3] == 1'b0, "R5 queues kept", d, 8'h00);
    wr(2'd0, 8'h30);
    rd(2'd3, d); chk(d[2] == 1'b1 && d[3] == 1'b1, "R7 flush both", d, 8'h0C);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'hA5);
    capture(64, b, st, sp);
    chk(b == 8'hA5 && sp == 1'b1, "R4 fresh frame", b, 8'hA5);
    repeat (128) @(negedge clk);
    pop(d); chk(d == 8'hA5, "R4 fresh rx", d, 8'hA5);

    // R10 full transmit queue and receive overrun
    wr(2'd0, 8'h02);
    for (int i = 0; i < 17; i++) wr(2'd2, 8'h40 + 8'(i));
    rd(2'd3, d); chk(d[1] == 1'b1, "R10 tx full", d[1], 1);
    wr(2'd0, 8'h03);
    for (int i = 0; i < 16; i++) begin
      capture(64, b, st, sp);
      chk(b == 8'h40 + 8'(i), "R10 queued order", b, 8'h40 + i);
    end
    repeat (128) @(negedge clk);
    rd(2'd3, d); chk(d[2] == 1'b1 && d[4] == 1'b1, "R10 17th dropped", d, 8'h15);
    wr(2'd2, 8'h77);
    capture(64, b, st, sp);
    repeat (128) @(negedge clk);
    rd(2'd3, d); chk(d[5] == 1'b1, "R10 overrun", d[5], 1);
    for (int i = 0; i < 16; i++) begin
      pop(d); chk(d == 8'h40 + 8'(i), "R10 rx kept", d, 8'h40 + i);
    end
    wr(2'd3, 8'h20);
    rd(2'd3, d); chk(d[5] == 1'b0, "R10 overrun w1c", d[5], 0);

    // R9 framing error and R8 directed receive
    lb = 1'b0;
    send(8'h5A, 1'b0, 64);
    repeat (128) @(negedge clk);
    rd(2'd3, d); chk(d[6] == 1'b1, "R9 ferr set", d[6], 1);
    pop(d); chk(d == 8'h5A, "R9 byte kept", d, 8'h5A);
    wr(2'd3, 8'h40);
    rd(2'd3, d); chk(d[6] == 1'b0, "R9 ferr w1c", d[6], 0);
    send(8'hC3, 1'b1, 64);
    repeat (128) @(negedge clk);
    rd(2'd3, d); chk(d[6] == 1'b0, "R9 good stop", d[6], 0);
    pop(d); chk(d == 8'hC3, "R8 rx byte", d, 8'hC3);

    // R8 false start: 3 ticks low
    @(negedge clk); rx_drv = 1'b0;
    repeat (12) @(negedge clk);
    rx_drv = 1'b1;
    repeat (800) @(negedge clk);
    rd(2'd3, d); chk(d[3] == 1'b1, "R8 false start", d[3], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule